// File: doc/BRIEF.md
# Gate Drive Source Selector

This block decides, for each of six low-side power switch channels, whether the external gate should be driven on. In the normal mode each channel is switched on when either its bit in the serial command register or its own direct parallel input asks for it. A mode select input hands the outer channel pairs to two shared PWM inputs: channels 0 and 1 follow the first PWM input, and channels 4 and 5 follow the second. Channels 2 and 3 keep their own direct inputs, and serial control is shut out for all channels.

The selected request is then qualified. Each channel must be permitted by the fault monitor, and no supply shutdown may be present: no over-voltage shutdown and no power-on reset or low logic supply. The result is registered once on the system clock. The registered mode state is also presented to the serial port, which uses it to report that PWM mode is in force.

All pins are plain level control and status signals. No data stream passes through the block, so it has no valid/ready handshake and applies no back-pressure. Inputs are sampled on every rising clock edge.

Top module: `gate_src_sel`

## Requirements
- R1: With `pwm_mode` low, the request for channel i (bit i of each vector) is `ser_cmd[i] | dir_in[i]`.
- R2: With `pwm_mode` high, `ser_cmd` has no effect on any channel, and `dir_in` bits 0, 1, 4 and 5 have no effect.
- R3: With `pwm_mode` high, channels 0 and 1 both take the value of `pwm_a`, and channels 4 and 5 both take the value of `pwm_b`.
- R4: With `pwm_mode` high, channels 2 and 3 each follow their own `dir_in` bit.
- R5: With `pwm_mode` low, `pwm_a` and `pwm_b` have no effect on any channel.
- R6: When `ovp_shutdown` is high, all six `gate_en` bits are low on the following cycle.
- R7: When `por_active` is high, all six `gate_en` bits are low on the following cycle.
- R8: When `fault_permit[i]` is low, `gate_en[i]` is low on the following cycle, and the other channels are unaffected.
- R9: `gate_en` is the qualified request registered once: a change on any input appears on `gate_en` after the next rising clock edge and not before. While `rst_n` is low, `gate_en` is all zeros.
- R10: `pwm_mode_flag` is `pwm_mode` delayed by one clock, and it is low during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_cmd | input | 6 | Serial command register; bit i requests channel i |
| dir_in | input | 6 | Direct parallel inputs; bit i requests channel i |
| pwm_mode | input | 1 | High selects PWM override mode |
| pwm_a | input | 1 | PWM input for channels 0 and 1 |
| pwm_b | input | 1 | PWM input for channels 4 and 5 |
| ovp_shutdown | input | 1 | Over-voltage shutdown flag |
| por_active | input | 1 | Power-on reset or low logic supply flag |
| fault_permit | input | 6 | Per-channel permit from the fault monitor |
| gate_en | output | 6 | Registered gate enables |
| pwm_mode_flag | output | 1 | Registered PWM mode status for the serial port |

## Verification
On every cycle the assertions check these properties: both shutdown flags clear the next gate vector; a withheld permit clears its channel; the paired channels agree in PWM mode; and with no requests present and normal mode selected, nothing turns on. The source choice itself can only be shown by the bench scenarios. These include proving that serial bits and the outer direct inputs are ignored in PWM mode, that the PWM inputs are ignored in normal mode, and that channels 2 and 3 keep their own control. The bench scenarios also cover the exact one-cycle latency, the reset values and mode switches in mid-stream.

// File: rtl/gss_pkg.sv
package gss_pkg;
  typedef enum logic [1:0] {
    SRC_OR     = 2'd0,
    SRC_PWM_A  = 2'd1,
    SRC_PWM_B  = 2'd2,
    SRC_DIRECT = 2'd3
  } src_sel_e;

  // Source of channel idx out of n channels in override mode.
  function automatic src_sel_e override_src(input int idx, input int n);
    if (idx == 0 || idx == 1)          return SRC_PWM_A;
    else if (idx == n - 2 || idx == n - 1) return SRC_PWM_B;
    else                               return SRC_DIRECT;
  endfunction
endpackage

// File: rtl/gss_req_mux.sv
module gss_req_mux
  import gss_pkg::*;
#(
  parameter int NUM_CH = 6
) (
  input  logic [NUM_CH-1:0] ser_cmd,
  input  logic [NUM_CH-1:0] dir_in,
  input  logic              pwm_mode,
  input  logic              pwm_a,
  input  logic              pwm_b,
  output logic [NUM_CH-1:0] req
);
  localparam int LAST = NUM_CH - 1;

  for (genvar ch = 0; ch <= LAST; ch++) begin : g_chan
    localparam src_sel_e OVR_SRC = override_src(ch, NUM_CH);
    logic ovr_req;

    if (OVR_SRC == SRC_PWM_A) begin : g_pa
      assign ovr_req = pwm_a;
    end else if (OVR_SRC == SRC_PWM_B) begin : g_pb
      assign ovr_req = pwm_b;
    end else begin : g_dir
      assign ovr_req = dir_in[ch];
    end

    assign req[ch] = pwm_mode ? ovr_req : (ser_cmd[ch] | dir_in[ch]);
  end
endmodule

// File: rtl/gss_gate_reg.sv
module gss_gate_reg #(
  parameter int NUM_CH = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] req,
  input  logic [NUM_CH-1:0] permit,
  input  logic              kill,
  input  logic              mode_in,
  output logic [NUM_CH-1:0] gate_q,
  output logic              mode_q
);
  logic [NUM_CH-1:0] gate_d;

  assign gate_d = kill ? '0 : (req & permit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= '0;
      mode_q <= 1'b0;
    end else begin
      gate_q <= gate_d;
      mode_q <= mode_in;
    end
  end

  AST_PERMIT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (permit != '1) |=> ((gate_q & ~$past(permit)) == '0)); // R8

  AST_KILL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (gate_q == '0)); // R6
endmodule

// File: rtl/gate_src_sel.sv
module gate_src_sel #(
  parameter int NUM_CH = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] ser_cmd,
  input  logic [NUM_CH-1:0] dir_in,
  input  logic              pwm_mode,
  input  logic              pwm_a,
  input  logic              pwm_b,
  input  logic              ovp_shutdown,
  input  logic              por_active,
  input  logic [NUM_CH-1:0] fault_permit,
  output logic [NUM_CH-1:0] gate_en,
  output logic              pwm_mode_flag
);
  localparam int PB_LO = NUM_CH - 2;
  localparam int PB_HI = NUM_CH - 1;

  logic [NUM_CH-1:0] req;
  logic              kill;

  assign kill = ovp_shutdown | por_active;

  gss_req_mux #(.NUM_CH(NUM_CH)) u_mux (
    .ser_cmd  (ser_cmd),
    .dir_in   (dir_in),
    .pwm_mode (pwm_mode),
    .pwm_a    (pwm_a),
    .pwm_b    (pwm_b),
    .req      (req)
  );

  gss_gate_reg #(.NUM_CH(NUM_CH)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .permit  (fault_permit),
    .kill    (kill),
    .mode_in (pwm_mode),
    .gate_q  (gate_en),
    .mode_q  (pwm_mode_flag)
  );

  AST_OVP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ovp_shutdown |=> (gate_en == '0)); // R6

  AST_POR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    por_active |=> (gate_en == '0)); // R7

  AST_PAIR_A_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_mode && fault_permit[0] && fault_permit[1])
      |=> (gate_en[0] == gate_en[1])); // R3

  AST_PAIR_B_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_mode && fault_permit[PB_LO] && fault_permit[PB_HI])
      |=> (gate_en[PB_LO] == gate_en[PB_HI])); // R3

  AST_IDLE_NO_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwm_mode && ser_cmd == '0 && dir_in == '0) |=> (gate_en == '0)); // R5
endmodule

// File: tb/gate_src_sel_test.sv
module gate_src_sel_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] ser_cmd = '0, dir_in = '0, fault_permit = '1;
  logic       pwm_mode = 1'b0, pwm_a = 1'b0, pwm_b = 1'b0;
  logic       ovp_shutdown = 1'b0, por_active = 1'b0;
  logic [5:0] gate_en;
  logic       pwm_mode_flag;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gate_src_sel uut (
    .clk(clk), .rst_n(rst_n), .ser_cmd(ser_cmd), .dir_in(dir_in),
    .pwm_mode(pwm_mode), .pwm_a(pwm_a), .pwm_b(pwm_b),
    .ovp_shutdown(ovp_shutdown), .por_active(por_active),
    .fault_permit(fault_permit), .gate_en(gate_en),
    .pwm_mode_flag(pwm_mode_flag)
  );

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Drive at falling edge, let one rising edge pass, sample just after it.
  task automatic drive(input logic [5:0] s, input logic [5:0] d, input logic m,
                       input logic a, input logic b);
    @(negedge clk);
    ser_cmd = s; dir_in = d; pwm_mode = m; pwm_a = a; pwm_b = b;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    drive(6'h3F, 6'h3F, 1'b1, 1'b1, 1'b1);
    step();
    chk("R9 reset gate", gate_en, 6'h00);
    chk("R10 reset flag", {5'b0, pwm_mode_flag}, 6'h00);
    drive(6'h00, 6'h00, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_normal_or();
    drive(6'b000101, 6'b100000, 1'b0, 1'b0, 1'b0); step();
    chk("R1 or pattern 1", gate_en, 6'b100101);
    drive(6'b000000, 6'b011010, 1'b0, 1'b0, 1'b0); step();
    chk("R1 direct only", gate_en, 6'b011010);
    drive(6'b110011, 6'b010110, 1'b0, 1'b0, 1'b0); step();
    chk("R1 overlap", gate_en, 6'b110111);
  endtask

  task automatic t_pwm_ignored();
    drive(6'b000000, 6'b000000, 1'b0, 1'b1, 1'b1); step();
    chk("R5 pwm high idle", gate_en, 6'b000000);
    drive(6'b001000, 6'b000000, 1'b0, 1'b1, 1'b0); step();
    chk("R5 pwm with serial", gate_en, 6'b001000);
  endtask

  task automatic t_override_pairs();
    drive(6'b000000, 6'b000000, 1'b1, 1'b1, 1'b0); step();
    chk("R3 pwm_a pair", gate_en, 6'b000011);
    drive(6'b000000, 6'b000000, 1'b1, 1'b0, 1'b1); step();
    chk("R3 pwm_b pair", gate_en, 6'b110000);
    chk("R10 flag high", {5'b0, pwm_mode_flag}, 6'h01);
  endtask

  task automatic t_override_ignores();
    drive(6'b111111, 6'b110011, 1'b1, 1'b0, 1'b0); step();
    chk("R2 serial and outer direct ignored", gate_en, 6'b000000);
    drive(6'b111111, 6'b000100, 1'b1, 1'b0, 1'b0); step();
    chk("R4 ch2 direct", gate_en, 6'b000100);
    drive(6'b000000, 6'b001000, 1'b1, 1'b1, 1'b1); step();
    chk("R4 ch3 direct with pwm", gate_en, 6'b111011);
  endtask

  task automatic t_latency_and_flag();
    drive(6'b000000, 6'b000000, 1'b0, 1'b0, 1'b0); step();
    @(negedge clk); ser_cmd = 6'b010010;
    #1 chk("R9 no change before edge", gate_en, 6'b000000);
    step();
    chk("R9 change after edge", gate_en, 6'b010010);
    @(negedge clk); pwm_mode = 1'b1;
    #1 chk("R10 flag before edge", {5'b0, pwm_mode_flag}, 6'h00);
    step();
    chk("R10 flag after edge", {5'b0, pwm_mode_flag}, 6'h01);
    chk("R2 mode switch drops serial", gate_en, 6'b000000);
    drive(6'b000000, 6'b000000, 1'b0, 1'b0, 1'b0); step();
  endtask

  task automatic t_shutdowns();
    drive(6'h3F, 6'h00, 1'b0, 1'b0, 1'b0);
    ovp_shutdown = 1'b1; step();
    chk("R6 over-voltage", gate_en, 6'h00);
    @(negedge clk); ovp_shutdown = 1'b0; step();
    chk("R6 recovery", gate_en, 6'h3F);
    @(negedge clk); por_active = 1'b1; step();
    chk("R7 power-on reset", gate_en, 6'h00);
    @(negedge clk); por_active = 1'b0; pwm_mode = 1'b1; pwm_a = 1'b1; pwm_b = 1'b1;
    dir_in = 6'b001100; ovp_shutdown = 1'b1; step();
    chk("R6 over-voltage in pwm mode", gate_en, 6'h00);
    @(negedge clk); ovp_shutdown = 1'b0; step();
    chk("R3 pwm after shutdown", gate_en, 6'h3F);
  endtask

  task automatic t_permit();
    drive(6'h3F, 6'h00, 1'b0, 1'b0, 1'b0);
    fault_permit = 6'b101110; step();
    chk("R8 permit mask", gate_en, 6'b101110);
    @(negedge clk); fault_permit = 6'b111101; pwm_mode = 1'b1; pwm_a = 1'b1; step();
    chk("R8 permit in pwm mode", gate_en, 6'b000001);
    @(negedge clk); fault_permit = '1; step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_normal_or();
    t_pwm_ignored();
    t_override_pairs();
    t_override_ignores();
    t_latency_and_flag();
    t_shutdowns();
    t_permit();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule